// File: doc/BRIEF.md
# Virtual Table Base Control Register

This block is a 64-bit control register. It records where a per-virtual-processor configuration table sits in memory, along with the attributes used to reach that table. Software writes the register through a plain write port that has one strobe per byte lane. The current contents are always visible on a read-data bus. Before a write is stored, any reserved field code is replaced with a legal one. As a result, the stored and read-back value is always something the rest of the chip can act on directly.

When a write turns the table-enable bit on, the block sends a one-cycle request to a downstream table engine. One request kind asks the engine to reload the table from memory. The other tells the engine that the table holds only zeros. A write-only hint bit in that same write decides which kind is sent. The block then waits for the engine's done signal. If software turns the enable bit off while a request is still outstanding, the block sends an abort pulse and latches an error flag until reset.

A mode input selects an older layout. In that layout the enable, indirect and sizing fields do not exist, and the low five bits hold an interrupt-ID width. In this mode the block also checks a presented virtual interrupt ID against that width.

Top module: `vtb_base_ctrl`

## Requirements
- R1: After reset the enable bit, busy, the error flag and all three request pulses are 0. Every stored field is 0, so in the normal layout `rd_data` reads 64'h0800_0000_0000_0000 (entry size 1 at bits 61:59).
- R2: A write changes only the byte lanes whose `wr_strb` bit is set. Strobe bit i covers `wr_data[8i+7:8i]`. A write with all strobes clear changes nothing.
- R3: The page-size field at bits 54:53 (00 = 4 KB, 01 = 16 KB, 10 = 64 KB) keeps the codes 00, 01 and 10 as written. A written 11 is stored and read back as 10.
- R4: The shareability field at bits 11:10 keeps the codes 00, 01 and 10 as written. A written 11 is stored and read back as 00.
- R5: Bit 52 (zero hint) and bit 62 always read 0. Bits 61:59 read the constant ENTRY_DWORDS-1, which is 3'b001 by default, and writes to them have no effect.
- R6: Bits 51:12 hold the table address. Bits at or above PA_BITS (default 48, so bits 51:48) read 0 whatever is written.
- R7: In the normal layout, a write that takes bit 63 from 0 to 1 while the block is idle produces a single-cycle pulse in the cycle after the write. The pulse is on `act_reload` if bit 52 of that write is 0, or on `act_zero` if it is 1.
- R8: The zero hint has no effect unless the same write raises bit 63 from 0 to 1. A write with bit 52 set while bit 63 is already 1 produces no pulse.
- R9: `busy` rises with each request and stays high until the engine asserts `act_done`. A 0-to-1 enable write made while `busy` is high produces no request.
- R10: Clearing bit 63 while a request is outstanding gives a one-cycle `act_abort` pulse and sets `abort_err`. `busy` stays high until `act_done` arrives. `abort_err` stays set until reset.
- R11: In the legacy layout, bits 63:59, 55:52 and 6:5 read 0. Writes to bit 63 neither change the enable bit nor start a request. Bits 4:0 store and read back the ID-bit count minus one.
- R12: In the legacy layout, `lookup_oor` is 1 for every ID if bits 4:0 are below 13. Otherwise it is 1 exactly when `lookup_id` is at least 2^(bits 4:0 + 1). In the normal layout it is always 0.
- R13: With HAS_INDIRECT=1, bit 55 (two-level table) is readable and writable in the normal layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | 1 selects the legacy layout |
| wr_en | input | 1 | Register write this cycle |
| wr_strb | input | 8 | Byte-lane write strobes |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Current register contents, legalised |
| act_reload | output | 1 | One-cycle request: reload table from memory |
| act_zero | output | 1 | One-cycle request: table is all zeros |
| act_abort | output | 1 | One-cycle pulse: outstanding request cancelled |
| act_done | input | 1 | Engine finished the outstanding request |
| busy | output | 1 | A request is outstanding |
| abort_err | output | 1 | Sticky flag: enable cleared mid-request |
| tbl_valid | output | 1 | Enable bit (normal layout) |
| tbl_base | output | PA_BITS | Table byte address, low 12 bits zero |
| lookup_id | input | IDW | Virtual interrupt ID to range-check |
| lookup_oor | output | 1 | ID is out of range (legacy layout) |

## Verification
The hardest state to reach from the ports is the drain condition. In it, software has already cancelled a request, but the engine has not yet acknowledged it, so a fresh enable must be swallowed. The stimulus gets there in three steps. It raises the enable with the zero hint, holds `act_done` low, and clears the enable. It then raises the enable again before releasing `act_done`. After that it confirms that no request pulse appears and that the error flag survives the acknowledgment. Byte-lane merging is covered by a run of partial-strobe writes. Each of these writes lands on a field that spans a lane boundary, which shows that the folding rules act on the merged value rather than on the raw data.

// File: rtl/vtb_pkg.sv
// Package: shared field record, handshake states and fixed bit positions
// for the virtual table base control register.
package vtb_pkg;

    localparam int REG_W      = 64;
    localparam int ADDR_LSB   = 12;
    localparam int ADDR_FLD_W = 40;
    localparam int MIN_IDBITS = 13;

    // Bit positions that the downstream decoders rely on.
    localparam int EN_BIT     = 63;
    localparam int HINT_BIT   = 52;
    localparam int IND_BIT    = 55;

    typedef struct packed {
        logic                  valid;
        logic                  indirect;
        logic [1:0]            page;
        logic [2:0]            outer;
        logic [ADDR_FLD_W-1:0] addr;
        logic [1:0]            share;
        logic [2:0]            inner;
        logic [6:0]            low7;
    } vtb_fields_t;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_BUSY  = 2'd1,
        ACT_DRAIN = 2'd2
    } act_state_e;

endpackage

// File: rtl/vtb_wr_merge.sv
// Module: vtb_wr_merge
// Purpose: merges a strobed write onto the current read-back image and
// folds reserved codes, producing the next field record and the hint.
// Assumes: cur_rd already reads the hint bit as zero, so the hint seen
// here comes only from a lane being written now.
module vtb_wr_merge
    import vtb_pkg::*;
#(
    parameter int PA_BITS      = 48,
    parameter bit HAS_INDIRECT = 1'b1
) (
    input  logic              legacy,
    input  logic [REG_W-1:0]  cur_rd,
    input  vtb_fields_t       cur,
    input  logic [7:0]        wr_strb,
    input  logic [REG_W-1:0]  wr_data,
    output vtb_fields_t       nxt,
    output logic              hint
);

    localparam int ADDR_W = PA_BITS - ADDR_LSB;
    localparam logic [ADDR_FLD_W-1:0] AMASK = {ADDR_FLD_W{1'b1}} >> (ADDR_FLD_W - ADDR_W);

    logic [REG_W-1:0] lane_mask;
    logic [REG_W-1:0] merged;
    logic             ind_bit;

    // Expand each byte strobe over its eight bits.
    for (genvar i = 0; i < 8; i++) begin : g_lane
        assign lane_mask[8*i +: 8] = {8{wr_strb[i]}};
    end

    // Select whether the two-level table bit is implemented.
    if (HAS_INDIRECT) begin : g_ind
        assign ind_bit = merged[IND_BIT];
    end else begin : g_noind
        assign ind_bit = 1'b0;
    end

    assign merged = (cur_rd & ~lane_mask) | (wr_data & lane_mask);
    assign hint   = merged[HINT_BIT];

    // Decode the merged image into legal field values for either layout.
    always_comb begin
        nxt       = cur;
        nxt.outer = merged[58:56];
        nxt.addr  = merged[51:12] & AMASK;
        nxt.share = (merged[11:10] == 2'b11) ? 2'b00 : merged[11:10];
        nxt.inner = merged[9:7];
        if (legacy) begin
            nxt.low7[4:0] = merged[4:0];
        end else begin
            nxt.valid    = merged[EN_BIT];
            nxt.indirect = ind_bit;
            nxt.page     = (merged[54:53] == 2'b11) ? 2'b10 : merged[54:53];
            nxt.low7     = merged[6:0];
        end
    end

endmodule

// File: rtl/vtb_field_reg.sv
// Module: vtb_field_reg
// Purpose: holds the legalised fields and composes the read-back image
// for the selected layout.
// Assumes: nxt is already legal; this stage only stores it.
module vtb_field_reg
    import vtb_pkg::*;
#(
    parameter int ENTRY_DWORDS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             legacy,
    input  vtb_fields_t      nxt,
    output vtb_fields_t      cur,
    output logic [REG_W-1:0] rd_data
);

    localparam logic [2:0] ESZ = 3'(ENTRY_DWORDS - 1);

    // Capture the next record on a write; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (wr_en) begin
            cur <= nxt;
        end
    end

    // Build the read-back word; fields absent from a layout read zero.
    always_comb begin
        if (legacy) begin
            rd_data = {5'b0, cur.outer, 4'b0, cur.addr, cur.share,
                       cur.inner, 2'b0, cur.low7[4:0]};
        end else begin
            rd_data = {cur.valid, 1'b0, ESZ, cur.outer, cur.indirect,
                       cur.page, 1'b0, cur.addr, cur.share, cur.inner,
                       cur.low7};
        end
    end

endmodule

// File: rtl/vtb_act_ctrl.sv
// Module: vtb_act_ctrl
// Purpose: turns enable-bit transitions into reload / zero-init requests,
// tracks the outstanding request and reports cancellations.
// Assumes: cur_valid/nxt_valid come from the field store and merge stage
// of the same write; in legacy layout they never differ.
module vtb_act_ctrl
    import vtb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic legacy,
    input  logic cur_valid,
    input  logic nxt_valid,
    input  logic hint,
    input  logic done,
    output logic req_reload,
    output logic req_zero,
    output logic req_abort,
    output logic busy,
    output logic err
);

    act_state_e state;
    logic       en_rise;
    logic       en_fall;

    assign en_rise = wr_en && !legacy && !cur_valid &&  nxt_valid;
    assign en_fall = wr_en && !legacy &&  cur_valid && !nxt_valid;
    assign busy    = (state != ACT_IDLE);

    // Sequence requests, completions and cancellations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ACT_IDLE;
            req_reload <= 1'b0;
            req_zero   <= 1'b0;
            req_abort  <= 1'b0;
            err        <= 1'b0;
        end else begin
            req_reload <= 1'b0;
            req_zero   <= 1'b0;
            req_abort  <= 1'b0;
            unique case (state)
                ACT_IDLE: begin
                    if (en_rise) begin
                        req_reload <= !hint;
                        req_zero   <= hint;
                        state      <= ACT_BUSY;
                    end
                end
                ACT_BUSY: begin
                    if (done) begin
                        state <= ACT_IDLE;
                    end else if (en_fall) begin
                        req_abort <= 1'b1;
                        err       <= 1'b1;
                        state     <= ACT_DRAIN;
                    end
                end
                ACT_DRAIN: begin
                    if (done) begin
                        state <= ACT_IDLE;
                    end
                end
                default: state <= ACT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vtb_range_chk.sv
// Module: vtb_range_chk
// Purpose: flags a virtual interrupt ID that the legacy ID width cannot
// reach, or every ID when that width is below the minimum.
// Assumes: purely combinational; idbits holds width minus one.
module vtb_range_chk
    import vtb_pkg::*;
#(
    parameter int IDW = 32
) (
    input  logic           legacy,
    input  logic [4:0]     idbits,
    input  logic [IDW-1:0] id,
    output logic           oor
);

    logic [IDW:0] id_ext;
    logic [5:0]   width;
    logic         too_narrow;
    logic         beyond;

    // Compare the ID against 2^(idbits+1) by shifting out the legal bits.
    always_comb begin
        id_ext     = {1'b0, id};
        width      = {1'b0, idbits} + 6'd1;
        too_narrow = (idbits < 5'(MIN_IDBITS));
        beyond     = ((id_ext >> width) != '0);
        oor        = legacy && (too_narrow || beyond);
    end

endmodule

// File: rtl/vtb_base_ctrl.sv
// Module: vtb_base_ctrl (top)
// Purpose: 64-bit table base control register with byte-strobed writes,
// reserved-code folding, activation handshake and legacy range check.
// Assumes: single clock, synchronous active-low reset, rd_data is a
// combinational view of the stored state.
module vtb_base_ctrl
    import vtb_pkg::*;
#(
    parameter int PA_BITS      = 48,
    parameter int ENTRY_DWORDS = 2,
    parameter bit HAS_INDIRECT = 1'b1,
    parameter int IDW          = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               legacy_mode,
    input  logic               wr_en,
    input  logic [7:0]         wr_strb,
    input  logic [63:0]        wr_data,
    output logic [63:0]        rd_data,
    output logic               act_reload,
    output logic               act_zero,
    output logic               act_abort,
    input  logic               act_done,
    output logic               busy,
    output logic               abort_err,
    output logic               tbl_valid,
    output logic [PA_BITS-1:0] tbl_base,
    input  logic [IDW-1:0]     lookup_id,
    output logic               lookup_oor
);

    localparam int ADDR_W = PA_BITS - ADDR_LSB;

    vtb_fields_t cur;
    vtb_fields_t nxt;
    logic        hint;

    vtb_wr_merge #(
        .PA_BITS      (PA_BITS),
        .HAS_INDIRECT (HAS_INDIRECT)
    ) u_merge (
        .legacy  (legacy_mode),
        .cur_rd  (rd_data),
        .cur     (cur),
        .wr_strb (wr_strb),
        .wr_data (wr_data),
        .nxt     (nxt),
        .hint    (hint)
    );

    vtb_field_reg #(
        .ENTRY_DWORDS (ENTRY_DWORDS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .legacy  (legacy_mode),
        .nxt     (nxt),
        .cur     (cur),
        .rd_data (rd_data)
    );

    vtb_act_ctrl u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .legacy     (legacy_mode),
        .cur_valid  (cur.valid),
        .nxt_valid  (nxt.valid),
        .hint       (hint),
        .done       (act_done),
        .req_reload (act_reload),
        .req_zero   (act_zero),
        .req_abort  (act_abort),
        .busy       (busy),
        .err        (abort_err)
    );

    vtb_range_chk #(
        .IDW (IDW)
    ) u_range (
        .legacy (legacy_mode),
        .idbits (cur.low7[4:0]),
        .id     (lookup_id),
        .oor    (lookup_oor)
    );

    assign tbl_valid = cur.valid;
    assign tbl_base  = {cur.addr[ADDR_W-1:0], {ADDR_LSB{1'b0}}};

endmodule

// File: rtl/vtb_checker.sv
// Module: vtb_checker
// Purpose: temporal properties on the top-level ports, bound into
// vtb_base_ctrl.
module vtb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        legacy_mode,
    input logic [63:0] rd_data,
    input logic        act_reload,
    input logic        act_zero,
    input logic        act_abort,
    input logic        busy,
    input logic        abort_err,
    input logic        lookup_oor
);

    a_r7_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_reload && act_zero));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (act_reload || act_zero) |=> !(act_reload || act_zero));

    a_r9_req_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (act_reload || act_zero) |-> (busy && !$past(busy)));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |=> abort_err);

    a_r10_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
        act_abort |-> (abort_err && busy));

    a_r5_raz_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[52] && !rd_data[62]);

    a_r3_page_folded: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_mode |-> (rd_data[54:53] != 2'b11));

    a_r4_share_folded: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[11:10] != 2'b11);

    a_r11_legacy_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_mode |-> (rd_data[63:59] == 5'b0 && rd_data[55:52] == 4'b0
                         && rd_data[6:5] == 2'b0));

    a_r12_oor_legacy_only: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_mode |-> !lookup_oor);

endmodule

bind vtb_base_ctrl vtb_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .legacy_mode (legacy_mode),
    .rd_data     (rd_data),
    .act_reload  (act_reload),
    .act_zero    (act_zero),
    .act_abort   (act_abort),
    .busy        (busy),
    .abort_err   (abort_err),
    .lookup_oor  (lookup_oor)
);

// File: tb/sim_vtb_base_ctrl.sv
module sim_vtb_base_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_strb = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        act_reload, act_zero, act_abort;
    logic        act_done = 1'b0;
    logic        busy, abort_err, tbl_valid;
    logic [47:0] tbl_base;
    logic [31:0] lookup_id = '0;
    logic        lookup_oor;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vtb_base_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .legacy_mode (legacy_mode),
        .wr_en (wr_en), .wr_strb (wr_strb), .wr_data (wr_data),
        .rd_data (rd_data), .act_reload (act_reload), .act_zero (act_zero),
        .act_abort (act_abort), .act_done (act_done), .busy (busy),
        .abort_err (abort_err), .tbl_valid (tbl_valid), .tbl_base (tbl_base),
        .lookup_id (lookup_id), .lookup_oor (lookup_oor)
    );

    // Vector: {legacy, strobe, write data, expected read-back}
    localparam int NV = 9;
    localparam logic [136:0] VEC [NV] = '{
        {1'b0, 8'hFF, 64'h0000_0000_0000_0000, 64'h0800_0000_0000_0000}, // R5
        {1'b0, 8'hFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0FC0_FFFF_FFFF_F3FF}, // R3 R4 R6 R13
        {1'b0, 8'h01, 64'h0000_0000_0000_0000, 64'h0FC0_FFFF_FFFF_F300}, // R2
        {1'b0, 8'h40, 64'h0023_0000_0000_0000, 64'h0F20_FFFF_FFFF_F300}, // R2 R3 R6
        {1'b0, 8'h02, 64'h0000_0000_0000_0800, 64'h0F20_FFFF_FFFF_0800}, // R2 R4
        {1'b0, 8'h80, 64'h7800_0000_0000_0000, 64'h0820_FFFF_FFFF_0800}, // R5
        {1'b1, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0700_FFFF_FFFF_F39F}, // R11
        {1'b1, 8'h01, 64'h0000_0000_0000_000C, 64'h0700_FFFF_FFFF_F30C}, // R11
        {1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0F20_FFFF_FFFF_F30C}  // R2
    };

    task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One write cycle; returns at the negedge after the capturing edge.
    task automatic wr(input logic leg, input logic [7:0] s, input logic [63:0] d);
        @(negedge clk);
        legacy_mode = leg;
        wr_strb = s;
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        act_done = 1'b1;
        @(negedge clk);
        act_done = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk64("R1 rd_data", rd_data, 64'h0800_0000_0000_0000);
        chk1("R1 busy", busy, 1'b0);
        chk1("R1 abort_err", abort_err, 1'b0);
        chk1("R1 pulses", act_reload | act_zero | act_abort, 1'b0);
        chk1("R1 tbl_valid", tbl_valid, 1'b0);

        // Field vectors
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][136], VEC[i][135:128], VEC[i][127:64]);
            chk64($sformatf("R2/R3/R4/R5/R6/R11/R13 vector %0d", i), rd_data, VEC[i][63:0]);
            chk1($sformatf("R11 no request vector %0d", i), act_reload | act_zero, 1'b0);
        end

        // R12: legacy ID range checks (idbits = 12 after vector 7)
        legacy_mode = 1'b1;
        lookup_id = 32'h10;
        @(negedge clk);
        chk1("R12 narrow width flags all", lookup_oor, 1'b1);
        wr(1'b1, 8'h01, 64'h0D);
        lookup_id = 32'h3FFF;
        @(negedge clk);
        chk1("R12 in range", lookup_oor, 1'b0);
        lookup_id = 32'h4000;
        @(negedge clk);
        chk1("R12 beyond width", lookup_oor, 1'b1);
        wr(1'b1, 8'h01, 64'h1F);
        lookup_id = 32'hFFFF_FFFF;
        @(negedge clk);
        chk1("R12 full width", lookup_oor, 1'b0);
        legacy_mode = 1'b0;
        lookup_id = 32'h0;
        @(negedge clk);
        chk1("R12 normal layout", lookup_oor, 1'b0);

        // R7: enable rise with hint clear -> reload
        wr(1'b0, 8'h80, 64'h8000_0000_0000_0000);
        chk1("R7 reload pulse", act_reload, 1'b1);
        chk1("R7 no zero pulse", act_zero, 1'b0);
        chk1("R9 busy after request", busy, 1'b1);
        chk1("R7 tbl_valid", tbl_valid, 1'b1);
        @(negedge clk);
        chk1("R7 pulse width", act_reload, 1'b0);
        chk1("R9 busy held", busy, 1'b1);
        done_pulse();
        chk1("R9 busy cleared by done", busy, 1'b0);

        // R8: hint with enable already set
        wr(1'b0, 8'hC0, 64'h8010_0000_0000_0000);
        chk1("R8 hint ignored", act_reload | act_zero, 1'b0);
        chk1("R8 idle", busy, 1'b0);

        // R7: clear, then rise with hint set -> zero-init
        wr(1'b0, 8'h80, 64'h0);
        chk1("R7 clear no pulse", act_reload | act_zero | act_abort, 1'b0);
        wr(1'b0, 8'hC0, 64'h8010_0000_0000_0000);
        chk1("R7 zero pulse", act_zero, 1'b1);
        chk1("R7 no reload pulse", act_reload, 1'b0);
        chk1("R5 hint reads zero", rd_data[52], 1'b0);

        // R10: cancel while outstanding
        wr(1'b0, 8'h80, 64'h0);
        chk1("R10 abort pulse", act_abort, 1'b1);
        chk1("R10 err set", abort_err, 1'b1);
        chk1("R10 busy until done", busy, 1'b1);
        @(negedge clk);
        chk1("R10 abort width", act_abort, 1'b0);
        // R9: rise during drain is not a request
        wr(1'b0, 8'h80, 64'h8000_0000_0000_0000);
        chk1("R9 rise ignored while busy", act_reload | act_zero, 1'b0);
        done_pulse();
        chk1("R9 idle after done", busy, 1'b0);
        chk1("R10 err sticky after done", abort_err, 1'b1);

        // R11: legacy write to enable bit leaves it and starts nothing
        wr(1'b0, 8'h80, 64'h0);
        wr(1'b1, 8'h80, 64'h8000_0000_0000_0000);
        chk1("R11 no legacy request", act_reload | act_zero, 1'b0);
        chk1("R11 enable untouched", tbl_valid, 1'b0);

        // R1: reset mid-flight clears everything
        wr(1'b0, 8'h80, 64'h8000_0000_0000_0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk1("R1 busy cleared", busy, 1'b0);
        chk1("R1 err cleared", abort_err, 1'b0);
        chk64("R1 rd_data after reset", rd_data, 64'h0800_0000_0000_0000);

        finished = 1'b1;
        summary();
    end

endmodule